// File: doc/BRIEF.md
# DMA Interrupt Flag Register Bank

This block keeps the interrupt status flags of a five-channel DMA controller. Every channel has three event flags: transfer complete, half transfer and transfer error. A fourth, per-channel summary flag reads as the OR of those three. One-cycle event pulses from the transfer engine set the event flags. The flags are sticky: each stays set until software clears it.

Software sees the flags through a simple register port. The status word sits at offset 0x00 and is read-only. The clear word sits at offset 0x04 and is write-only in effect. A 1 written to a clear bit drops the matching flag, and a 0 written to it changes nothing. Each channel also has a summary clear bit that drops all of that channel's flags in one write.

Each channel drives an interrupt line that is high while its summary flag is set. Masking by per-channel enables is done outside this block.

Top module: `dma_irq_flag_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, every flag is cleared. After reset the status word reads 0x00000000 and every `chan_irq` bit is 0.
- R2: An event pulse sets a flag, and the flag reads back in the status word from the next cycle on. Channel c (0-based) owns bits 4c..4c+3 of the status word, laid out as: bit 4c+1 for `ev_done[c]`, bit 4c+2 for `ev_half[c]`, bit 4c+3 for `ev_err[c]`.
- R3: Status bit 4c (the summary flag) reads as the OR of bits 4c+1..4c+3, and `chan_irq[c]` equals that summary flag.
- R4: A write to offset 0x04 with bit 4c+1, 4c+2 or 4c+3 set clears only the matching event flag of channel c.
- R5: A write to offset 0x04 with bit 4c set clears all three event flags of channel c, and with them its summary flag and `chan_irq[c]`.
- R6: Zero bits in a clear write leave the matching flags as they were, and the flags of channels the write does not select are unchanged.
- R7: If an event pulse and a clear of the same flag happen in the same cycle, the flag ends up set.
- R8: Bits 31..20 of any read return zero, and 1s written to bits 31..20 of the clear word have no effect.
- R9: A read at offset 0x04 (or any offset other than 0x00) returns zero. A write to any offset other than 0x04 changes no flag.
- R10: With no event and no clear, every flag holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe of the register port |
| reg_waddr | input | 4 | Byte offset of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Byte offset of the read |
| reg_rdata | output | 32 | Read data (combinational from `reg_raddr`) |
| ev_done | input | 5 | Transfer-complete event pulse, one bit per channel |
| ev_half | input | 5 | Half-transfer event pulse, one bit per channel |
| ev_err | input | 5 | Transfer-error event pulse, one bit per channel |
| chan_irq | output | 5 | Per-channel interrupt, high while the summary flag is set |

## Verification
The flags are the only state in the block, and the read path from them to the status word is combinational. A flag that is wrongly set or cleared therefore shows up in the very next status read after the faulty edge, and a wrong summary flag shows up on `chan_irq` in the same cycle. The bench keeps its own model of all fifteen event flags. It reads the status word after every stimulus cycle, so a lost event, an over-wide clear or a set-versus-clear priority error is caught within one cycle of the edge that caused it.

// File: rtl/dmaif_pkg.sv
// Package: shared constants for the DMA interrupt flag bank.
// Holds the per-channel field layout and the two register offsets.
// Assumes byte offsets and a 4-bit field group per channel.
package dmaif_pkg;
    localparam int unsigned BITS_PER_CH = 4;
    localparam int unsigned EVT_PER_CH  = 3;
    // Event index inside a channel; the status field is index + 1.
    localparam int unsigned EVT_DONE    = 0;
    localparam int unsigned EVT_HALF    = 1;
    localparam int unsigned EVT_ERR     = 2;
    localparam int unsigned FLD_SUMMARY = 0;
    localparam int unsigned STAT_OFFSET = 0;
    localparam int unsigned CLR_OFFSET  = 4;

    // Bit position of field fld of channel ch in the status and clear words.
    function automatic int unsigned fld_pos(int unsigned ch, int unsigned fld);
        return ch * BITS_PER_CH + fld;
    endfunction
endpackage

// File: rtl/dmaif_chan_flags.sv
// Module: dmaif_chan_flags
// Holds the sticky event flags of one DMA channel and forms its summary flag.
// Assumes event pulses and clear requests last one cycle each. A set request
// takes priority over any clear of the same flag.
module dmaif_chan_flags #(
    parameter int unsigned EVT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_set,
    input  logic [EVT_N-1:0] evt_clr,
    input  logic             clr_all,
    output logic [EVT_N-1:0] evt_flag,
    output logic             any_flag
);
    genvar k;
    generate
        for (k = 0; k < EVT_N; k++) begin : g_flag
            // Sticky flag: reset, then set wins, then single or channel-wide clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    evt_flag[k] <= 1'b0;
                end else if (evt_set[k]) begin
                    evt_flag[k] <= 1'b1;
                end else if (evt_clr[k] || clr_all) begin
                    evt_flag[k] <= 1'b0;
                end
            end

            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                evt_set[k] |=> evt_flag[k]); // R7
            AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (!evt_set[k] && (evt_clr[k] || clr_all)) |=> !evt_flag[k]); // R4
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!evt_set[k] && !evt_clr[k] && !clr_all) |=> $stable(evt_flag[k])); // R10
        end
    endgenerate

    // Summary flag: OR of the channel's event flags.
    always_comb begin
        any_flag = |evt_flag;
    end
endmodule

// File: rtl/dmaif_clr_decode.sv
// Module: dmaif_clr_decode
// Turns a write to the clear offset into per-flag and per-channel clear
// strobes. Assumes a single-cycle write strobe. Writes to other offsets and
// to the reserved upper bits produce no strobe.
module dmaif_clr_decode
    import dmaif_pkg::*;
#(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_CH*EVT_PER_CH-1:0] clr_evt,
    output logic [NUM_CH-1:0]          clr_all
);
    localparam int unsigned USED_W = NUM_CH * BITS_PER_CH;

    logic hit;

    // Address match for the clear word.
    always_comb begin
        hit = wr_en && (waddr == ADDR_W'(CLR_OFFSET));
    end

    genvar c, k;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Channel-wide clear strobe from the summary bit.
            always_comb begin
                clr_all[c] = hit && wdata[fld_pos(c, FLD_SUMMARY)];
            end
            for (k = 0; k < EVT_PER_CH; k++) begin : g_evt
                // Single-flag clear strobe from the matching event bit.
                always_comb begin
                    clr_evt[c*EVT_PER_CH + k] = hit && wdata[fld_pos(c, k + 1)];
                end
            end
        end
        if (DATA_W > USED_W) begin : g_rsvd
            logic unused_rsvd;
            // Reserved write bits are decoded by nothing.
            always_comb begin
                unused_rsvd = ^wdata[DATA_W-1:USED_W];
            end
        end
    endgenerate

    AST_NO_STRAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (waddr == ADDR_W'(CLR_OFFSET))) |-> (clr_evt == '0 && clr_all == '0)); // R9
endmodule

// File: rtl/dmaif_rd_mux.sv
// Module: dmaif_rd_mux
// Combinational read port. Returns the status word at the status offset and
// zero everywhere else, including the clear offset and the reserved bits.
module dmaif_rd_mux
    import dmaif_pkg::*;
#(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             raddr,
    input  logic [NUM_CH*BITS_PER_CH-1:0] status,
    output logic [DATA_W-1:0]             rdata
);
    localparam int unsigned USED_W = NUM_CH * BITS_PER_CH;

    // Select the status word or zero.
    always_comb begin
        rdata = '0;
        if (raddr == ADDR_W'(STAT_OFFSET)) begin
            rdata[USED_W-1:0] = status;
        end
    end

    AST_CLR_WORD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr == ADDR_W'(CLR_OFFSET)) |-> (rdata == '0)); // R9
endmodule

// File: rtl/dma_irq_flag_bank.sv
// Module: dma_irq_flag_bank (top)
// Interrupt flag bank of a multi-channel DMA controller: sticky event flags
// set by engine pulses, cleared through a write-only clear word, read back
// through a status word, and one interrupt line per channel.
// Assumes a single clock and a synchronous active-low reset.
module dma_irq_flag_bank
    import dmaif_pkg::*;
#(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_half,
    input  logic [NUM_CH-1:0] ev_err,
    output logic [NUM_CH-1:0] chan_irq
);
    localparam int unsigned USED_W = NUM_CH * BITS_PER_CH;
    localparam int unsigned EVT_W  = NUM_CH * EVT_PER_CH;

    logic [EVT_W-1:0]  clr_evt;
    logic [NUM_CH-1:0] clr_all;
    logic [EVT_W-1:0]  evt_flag;
    logic [NUM_CH-1:0] summary;
    logic [USED_W-1:0] status;

    dmaif_clr_decode #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .clr_evt (clr_evt),
        .clr_all (clr_all)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic [EVT_PER_CH-1:0] set_vec;

            // Gather the channel's event pulses in field order.
            always_comb begin
                set_vec           = '0;
                set_vec[EVT_DONE] = ev_done[c];
                set_vec[EVT_HALF] = ev_half[c];
                set_vec[EVT_ERR]  = ev_err[c];
            end

            dmaif_chan_flags #(
                .EVT_N (EVT_PER_CH)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt_set  (set_vec),
                .evt_clr  (clr_evt[c*EVT_PER_CH +: EVT_PER_CH]),
                .clr_all  (clr_all[c]),
                .evt_flag (evt_flag[c*EVT_PER_CH +: EVT_PER_CH]),
                .any_flag (summary[c])
            );

            // Place summary and event flags into the channel's status field.
            always_comb begin
                status[c*BITS_PER_CH +: BITS_PER_CH] =
                    {evt_flag[c*EVT_PER_CH +: EVT_PER_CH], summary[c]};
            end

            AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_done[c] || ev_half[c] || ev_err[c]) |=> chan_irq[c]); // R3
            AST_CHAN_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_waddr == ADDR_W'(CLR_OFFSET) && reg_wdata[c*BITS_PER_CH]
                 && !ev_done[c] && !ev_half[c] && !ev_err[c]) |=> !chan_irq[c]); // R5
        end
    endgenerate

    // Interrupt lines follow the summary flags.
    always_comb begin
        chan_irq = summary;
    end

    dmaif_rd_mux #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr  (reg_raddr),
        .status (status),
        .rdata  (reg_rdata)
    );

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:USED_W] == '0); // R8
endmodule

// File: tb/sim_dma_irq_flag_bank.sv
// Scoreboard bench: driver tasks update a flag model and push expected read
// results; a monitor pops and compares them against the design's ports.
module sim_dma_irq_flag_bank;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  ev_done = '0, ev_half = '0, ev_err = '0;
    logic [4:0]  chan_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp_rd;
        logic [4:0]  exp_irq;
        string       tag;
    } item_t;
    item_t sbq[$];

    // Model: m_flag[c][k], k=0 done, 1 half, 2 err.
    bit m_flag [NCH][3];

    always #5 clk = ~clk;

    dma_irq_flag_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ev_done(ev_done), .ev_half(ev_half), .ev_err(ev_err), .chan_irq(chan_irq)
    );

    function automatic logic [31:0] model_status();
        logic [31:0] s = '0;
        for (int c = 0; c < NCH; c++) begin
            s[4*c+1] = m_flag[c][0];
            s[4*c+2] = m_flag[c][1];
            s[4*c+3] = m_flag[c][2];
            s[4*c]   = m_flag[c][0] | m_flag[c][1] | m_flag[c][2];
        end
        return s;
    endfunction

    function automatic logic [4:0] model_irq();
        logic [4:0] q = '0;
        for (int c = 0; c < NCH; c++) q[c] = m_flag[c][0] | m_flag[c][1] | m_flag[c][2];
        return q;
    endfunction

    // One stimulus cycle; model follows: set wins, then clear.
    task automatic cycle(input logic [4:0] d, input logic [4:0] h, input logic [4:0] e,
                         input logic wr, input logic [3:0] wa, input logic [31:0] wd);
        @(negedge clk);
        ev_done = d; ev_half = h; ev_err = e;
        reg_wr = wr; reg_waddr = wa; reg_wdata = wd;
        for (int c = 0; c < NCH; c++) begin
            bit [2:0] setv;
            setv = {e[c], h[c], d[c]};
            for (int k = 0; k < 3; k++) begin
                bit clr;
                clr = wr && (wa == 4'd4) && (wd[4*c] || wd[4*c+1+k]);
                if (setv[k]) m_flag[c][k] = 1'b1;
                else if (clr) m_flag[c][k] = 1'b0;
            end
        end
    endtask

    // Idle cycle with a read; expected value pushed for the monitor.
    task automatic check_read(input logic [3:0] ra, input string tag);
        item_t it;
        @(negedge clk);
        ev_done = '0; ev_half = '0; ev_err = '0; reg_wr = 1'b0; reg_wdata = '0;
        reg_raddr = ra;
        #1;
        it.exp_rd  = (ra == 4'd0) ? model_status() : 32'h0;
        it.exp_irq = model_irq();
        it.tag     = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compares queued expectations mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                total++;
                if (reg_rdata !== it.exp_rd) begin
                    bad++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp_rd);
                end
                total++;
                if (chan_irq !== it.exp_irq) begin
                    bad++;
                    $display("FAIL %s chan_irq actual=%b expected=%b", it.tag, chan_irq, it.exp_irq);
                end
            end
        end
    end

    task automatic clear_model();
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 3; k++) m_flag[c][k] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_read(4'd0, "R1 reset");

        // R2/R3: sparse events on several channels
        cycle(5'b00001, 5'b00100, 5'b10000, 1'b0, 4'd0, 32'h0);
        check_read(4'd0, "R2 sparse set");
        cycle(5'b00010, 5'b00000, 5'b00000, 1'b0, 4'd0, 32'h0);
        check_read(4'd0, "R3 summary");

        // R2: every flag on every channel
        cycle(5'b11111, 5'b11111, 5'b11111, 1'b0, 4'd0, 32'h0);
        check_read(4'd0, "R2 all set");

        // R6: all-zero clear write
        cycle('0, '0, '0, 1'b1, 4'd4, 32'h0);
        check_read(4'd0, "R6 zero write");

        // R4: single clear of channel 1 done (bit 5)
        cycle('0, '0, '0, 1'b1, 4'd4, 32'h0000_0020);
        check_read(4'd0, "R4 single clear");
        // R4: clear of channel 3 err (bit 15) and channel 4 half (bit 18)
        cycle('0, '0, '0, 1'b1, 4'd4, 32'h0004_8000);
        check_read(4'd0, "R4 two clears");

        // R8: reserved bits written, reads zero above bit 19
        cycle('0, '0, '0, 1'b1, 4'd4, 32'hFFF0_0000);
        check_read(4'd0, "R8 reserved write");

        // R9: write to status offset, reads at clear and other offsets
        cycle('0, '0, '0, 1'b1, 4'd0, 32'hFFFF_FFFF);
        check_read(4'd0, "R9 write to status offset");
        cycle('0, '0, '0, 1'b1, 4'd8, 32'hFFFF_FFFF);
        check_read(4'd4, "R9 read clear offset");
        check_read(4'd8, "R9 read other offset");

        // R5: channel-wide clear of channel 2 (bit 8)
        cycle('0, '0, '0, 1'b1, 4'd4, 32'h0000_0100);
        check_read(4'd0, "R5 channel clear");

        // R7: set with single and channel-wide clear of channel 0
        cycle('0, '0, 5'b00001, 1'b1, 4'd4, 32'h0000_0009);
        check_read(4'd0, "R7 set beats clear");
        cycle(5'b00010, '0, '0, 1'b1, 4'd4, 32'h0000_0010);
        check_read(4'd0, "R7 set beats channel clear");

        // R10: hold over idle cycles
        repeat (6) @(negedge clk);
        check_read(4'd0, "R10 hold");

        // R5: clear everything through summary bits
        cycle('0, '0, '0, 1'b1, 4'd4, 32'h0001_1111);
        check_read(4'd0, "R5 all channels clear");

        // R1: reset in the middle of a run
        cycle(5'b10101, 5'b01010, 5'b11000, 1'b0, 4'd0, 32'h0);
        check_read(4'd0, "R2 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        clear_model();
        rst_n = 1'b1;
        check_read(4'd0, "R1 mid-run reset");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule